// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer motion reports into five-byte serial mouse packets and holds the bytes in a small circular byte queue until a host reads them. A report is a strobe with signed horizontal and vertical movement and three button states. The block encodes each report into a sync byte that carries the buttons, a horizontal byte, a vertical byte and two padding bytes. It then writes the five bytes into the queue on consecutive cycles.

The host side sees a show-ahead byte port and a data-available flag. The flag stays high while any byte remains in the queue. A read strobe removes the byte currently shown. A packet goes into the queue only if the whole packet fits, so the host never sees part of a packet. A report that arrives while a packet is still being written is held in a single slot and encoded once the current packet is complete.

Top module: `mouse_packet_queue`

## Requirements
- R1: After reset the queue is empty: `rxAvail` is 0 and `rdData` is 0x00.
- R2: The first byte of a packet is 0x80 with bits 2..0 active-low buttons: `evtBtn[2]` (left) pressed clears bit 2, `evtBtn[1]` (middle) clears bit 1, `evtBtn[0]` (right) clears bit 0; no button pressed gives 0x87.
- R3: The second byte is `evtDx` (two's complement) clamped to -127..+127 and sent as an 8-bit two's complement value (+127 = 0x7F, -127 = 0x81).
- R4: The third byte is the arithmetic negation of `evtDy`, clamped in the same way; negating the most negative input gives +127.
- R5: The fourth and fifth bytes are 0x00, and the five bytes of a packet enter the queue on five consecutive cycles in the order sync, X, Y, zero, zero.
- R6: When a strobe is accepted at rising edge N, the first byte enters the queue at edge N+1, so `rxAvail` is still 0 after edge N and is 1 after edge N+1.
- R7: A report is accepted only if at least five queue slots are free when it is taken up. Otherwise the whole report is discarded and the queue contents stay as they were. With a queue depth of 16, exactly five free slots is enough.
- R8: A read strobe while the queue is empty has no effect, and `rdData` shows 0x00 while the queue is empty.
- R9: Bytes leave in the order they entered. `rxAvail` stays 1 after each read while bytes remain, and drops to 0 after the last byte is read.
- R10: A strobe that arrives while a packet is being written is held in one slot and encoded right after that packet. If several arrive, only the most recent is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Report strobe, one cycle per report |
| evtDx | input | DELTA_W | Horizontal movement, two's complement |
| evtDy | input | DELTA_W | Vertical movement, two's complement |
| evtBtn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| rdEn | input | 1 | Read strobe, removes the byte shown on rdData |
| rdData | output | 8 | Oldest queued byte, 0x00 when empty |
| rxAvail | output | 1 | High while the queue holds at least one byte |

## Verification
A wrong byte index or a wrong clamp shows up at `rdData` as soon as that packet position is read. A counter that loses track of the free space shows up either as a missing final packet or as a fifth packet in a queue that should hold only sixteen bytes. Both appear on the first drain after the queue has been filled. A lost hold slot shows as an absent packet after a back-to-back burst. A stale hold slot shows as a duplicated packet. Both become visible within about twelve cycles of the burst.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN = 5;

  typedef struct packed {
    logic       capture;   // load the working report
    logic       fromHold;  // capture source is the hold slot
    logic       stash;     // copy the incoming report into the hold slot
    logic       push;      // write the selected byte into the queue
    logic [2:0] sel;       // byte position inside the packet
  } mpeStrobes_t;
endpackage

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic        room,
  output mpeStrobes_t strb
);
  localparam logic [2:0] LAST_IDX = 3'(PKT_LEN - 1);

  logic       busy;
  logic       holdValid;
  logic [2:0] idx;

  always_comb begin
    strb      = '0;
    strb.sel  = idx;
    strb.push = busy;
    if (busy) begin
      strb.stash = evtValid;
    end else begin
      strb.fromHold = holdValid;
      strb.capture  = (holdValid | evtValid) & room;
      strb.stash    = holdValid & evtValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      holdValid <= 1'b0;
      idx       <= '0;
    end else if (busy) begin
      holdValid <= holdValid | evtValid;
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 3'd1;
      end
    end else begin
      holdValid <= holdValid & evtValid;
      busy      <= strb.capture;
      idx       <= '0;
    end
  end
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo
  import mpe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       push,
  input  logic [7:0] pushByte,
  input  logic       rdEn,
  output logic       room,
  output logic [7:0] rdData,
  output logic       rxAvail
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign doPush  = push & (count != CNT_W'(DEPTH));
  assign doPop   = rdEn & (count != '0);
  assign room    = (CNT_W'(DEPTH) - count) >= CNT_W'(PKT_LEN);
  assign rxAvail = count != '0;
  assign rdData  = (count != '0) ? mem[rdPtr] : 8'h00;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DELTA_W-1:0] evtDx,
  input  logic [DELTA_W-1:0] evtDy,
  input  logic [2:0]         evtBtn,
  input  mpeStrobes_t        strb,
  input  logic               rdEn,
  output logic               room,
  output logic [7:0]         rdData,
  output logic               rxAvail
);
  logic signed [DELTA_W-1:0] curDx, curDy, holdDx, holdDy;
  logic [2:0]                curBtn, holdBtn;
  logic signed [DELTA_W:0]   dxExt, dyNeg;
  logic [7:0]                pushByte;

  function automatic logic [7:0] clamp8(input logic signed [DELTA_W:0] v);
    if (v > 127)       return 8'h7F;
    else if (v < -127) return 8'h81;
    else               return v[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDx   <= '0;
      curDy   <= '0;
      curBtn  <= '0;
      holdDx  <= '0;
      holdDy  <= '0;
      holdBtn <= '0;
    end else begin
      if (strb.capture) begin
        curDx  <= strb.fromHold ? holdDx  : $signed(evtDx);
        curDy  <= strb.fromHold ? holdDy  : $signed(evtDy);
        curBtn <= strb.fromHold ? holdBtn : evtBtn;
      end
      if (strb.stash) begin
        holdDx  <= $signed(evtDx);
        holdDy  <= $signed(evtDy);
        holdBtn <= evtBtn;
      end
    end
  end

  assign dxExt = {curDx[DELTA_W-1], curDx};
  assign dyNeg = -$signed({curDy[DELTA_W-1], curDy});

  always_comb begin
    case (strb.sel)
      3'd0:    pushByte = {5'b10000, ~curBtn};
      3'd1:    pushByte = clamp8(dxExt);
      3'd2:    pushByte = clamp8(dyNeg);
      default: pushByte = 8'h00;
    endcase
  end

  mpe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.push),
    .pushByte (pushByte),
    .rdEn     (rdEn),
    .room     (room),
    .rdData   (rdData),
    .rxAvail  (rxAvail)
  );
endmodule

// File: rtl/mouse_packet_queue.sv
module mouse_packet_queue
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtValid,
  input  logic [DELTA_W-1:0] evtDx,
  input  logic [DELTA_W-1:0] evtDy,
  input  logic [2:0]         evtBtn,
  input  logic               rdEn,
  output logic [7:0]         rdData,
  output logic               rxAvail
);
  mpeStrobes_t strb;
  logic        room;

  mpe_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .room     (room),
    .strb     (strb)
  );

  mpe_datapath #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtDx   (evtDx),
    .evtDy   (evtDy),
    .evtBtn  (evtBtn),
    .strb    (strb),
    .rdEn    (rdEn),
    .room    (room),
    .rdData  (rdData),
    .rxAvail (rxAvail)
  );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker
  import mpe_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rxAvail,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       pushStb,
  input logic [2:0] pushSel
);
  // R8: an empty queue presents zero
  a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rxAvail |-> rdData == 8'h00);

  // R9: data stays available until it is read
  a_r9_avail_holds: assert property (@(posedge clk) disable iff (!rstN)
    rxAvail && !rdEn |=> rxAvail);

  // R5: packet bytes are written back to back
  a_r5_burst_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    pushStb && pushSel != 3'(PKT_LEN - 1) |=> pushStb && pushSel == $past(pushSel) + 3'd1);

  // R5: every burst starts with the sync byte
  a_r5_starts_with_sync: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pushStb) |-> pushSel == 3'd0);

  // R6: availability only rises after a write
  a_r6_avail_from_push: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxAvail) |-> $past(pushStb));
endmodule

bind mouse_packet_queue mpe_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rxAvail (rxAvail),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .pushStb (strb.push),
  .pushSel (strb.sel)
);

// File: tb/tb_mouse_packet_queue.sv
module tb_mouse_packet_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DELTA_W    = 10;
  localparam int DEPTH      = 16;
  localparam int NVEC       = 7;

  // {dx[46:37], dy[36:27], btn[26:24], sync[23:16], xByte[15:8], yByte[7:0]}
  localparam logic [46:0] VEC [NVEC] = '{
    {10'h005, 10'h003, 3'b000, 8'h87, 8'h05, 8'hFD},
    {10'h338, 10'h338, 3'b100, 8'h83, 8'h81, 8'h7F},
    {10'h12C, 10'h1FF, 3'b111, 8'h80, 8'h7F, 8'h81},
    {10'h200, 10'h200, 3'b010, 8'h85, 8'h81, 8'h7F},
    {10'h07F, 10'h381, 3'b001, 8'h86, 8'h7F, 8'h7F},
    {10'h381, 10'h080, 3'b000, 8'h87, 8'h81, 8'h81},
    {10'h000, 10'h000, 3'b101, 8'h82, 8'h00, 8'h00}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               evtValid = 1'b0;
  logic [DELTA_W-1:0] evtDx = '0;
  logic [DELTA_W-1:0] evtDy = '0;
  logic [2:0]         evtBtn = '0;
  logic               rdEn = 1'b0;
  logic [7:0]         rdData;
  logic               rxAvail;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mouse_packet_queue #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtDx(evtDx), .evtDy(evtDy),
    .evtBtn(evtBtn), .rdEn(rdEn), .rdData(rdData), .rxAvail(rxAvail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pktByte(input int v, input int pos);
    case (pos)
      0:       return VEC[v][23:16];
      1:       return VEC[v][15:8];
      2:       return VEC[v][7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic sendEvt(input int v);
    @(negedge clk);
    evtValid = 1'b1;
    evtDx    = VEC[v][46:37];
    evtDy    = VEC[v][36:27];
    evtBtn   = VEC[v][26:24];
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic popCheck(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(rxAvail == 1'b1, req, "rxAvail before read", 16'(rxAvail), 16'd1);
    check(rdData == exp, req, "byte", 16'(rdData), 16'(exp));
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rxAvail == 1'b0, "R1", "rxAvail after reset", 16'(rxAvail), 16'd0);
    check(rdData == 8'h00, "R1", "rdData after reset", 16'(rdData), 16'h00);

    // Table walk: R2, R3, R4, R5, R6, R9
    for (int v = 0; v < NVEC; v++) begin
      sendEvt(v);
      check(rxAvail == 1'b0, "R6", "rxAvail after accepting edge", 16'(rxAvail), 16'd0);
      @(negedge clk);
      check(rxAvail == 1'b1, "R6", "rxAvail one edge later", 16'(rxAvail), 16'd1);
      idle(6);
      popCheck(pktByte(v, 0), "R2");
      popCheck(pktByte(v, 1), "R3");
      popCheck(pktByte(v, 2), "R4");
      popCheck(8'h00, "R5");
      popCheck(8'h00, "R5");
      @(negedge clk);
      check(rxAvail == 1'b0, "R9", "rxAvail after draining packet", 16'(rxAvail), 16'd0);
    end

    // R8: read from empty queue
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == 8'h00, "R8", "empty read data", 16'(rdData), 16'h00);
    check(rxAvail == 1'b0, "R8", "empty read leaves queue empty", 16'(rxAvail), 16'd0);
    sendEvt(6);
    idle(7);
    popCheck(8'h82, "R8");
    for (int i = 1; i < 5; i++) popCheck(8'h00, "R8");

    // R7: fill with three packets, free exactly five, then one fits and one is dropped
    for (int p = 0; p < 3; p++) begin
      sendEvt(p);
      idle(7);
    end
    for (int i = 0; i < 4; i++) popCheck(pktByte(0, i), "R9");
    sendEvt(3);
    idle(7);
    sendEvt(4);
    idle(7);
    popCheck(pktByte(0, 4), "R7");
    for (int p = 1; p < 4; p++)
      for (int i = 0; i < 5; i++) popCheck(pktByte(p, i), "R7");
    @(negedge clk);
    check(rxAvail == 1'b0, "R7", "report without room was dropped", 16'(rxAvail), 16'd0);

    // R10: three strobes during one packet; the last one is kept
    sendEvt(1);
    sendEvt(2);
    sendEvt(5);
    idle(14);
    for (int i = 0; i < 5; i++) popCheck(pktByte(1, i), "R10");
    for (int i = 0; i < 5; i++) popCheck(pktByte(5, i), "R10");
    @(negedge clk);
    check(rxAvail == 1'b0, "R10", "no extra packet from overwritten hold", 16'(rxAvail), 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule